// File: doc/BRIEF.md
# Shared Interrupt State Register Bank

This block holds the per-line state of a configurable set of shared interrupt lines behind a byte-addressed register window. Each line carries six pieces of state: an enable bit, a pending bit, an active bit, a group bit, a group-modifier bit and a two-bit non-secure access level. Enable, pending and active are each reached through a pair of windows. One window of the pair sets bits when a 1 is written. The other clears bits when a 1 is written. A read of either window returns the same state. The group and group-modifier bits are plain one-bit-per-line fields. The access levels are packed two bits per line.

Every request carries a secure flag. When security is on, a non-secure caller sees and changes only the bits that the line's group and access level allow. The thresholds differ by window. A static `sec_off` input turns the security filter off. The complete state vectors are exported so that a neighbouring selector can use them. A one-cycle `upd_strobe` tells that selector to re-evaluate after any enable or pending bit has changed.

The request port accepts one access on every cycle and never applies back-pressure, so it has no ready signal. Read data comes back on `rsp_valid`/`rsp_rdata` exactly one cycle after a read is accepted. The response path cannot be stalled, so a consumer must take `rsp_rdata` in the cycle that `rsp_valid` is high.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, every group, enable, pending, active, group-modifier and access-level bit is 0, and `rsp_valid` and `upd_strobe` are 0.
- R2: The one-bit windows start at the following byte addresses: 0x080 group, 0x100 set-enable, 0x180 clear-enable, 0x200 set-pending, 0x280 clear-pending, 0x300 set-active, 0x380 clear-active, and 0xD00 group-modifier. Each of these windows is 0x80 bytes long. Data bit i of byte offset k belongs to line 8k+i.
- R3: Writing 1 to a set window sets the bit, and writing 1 to a clear window clears it. Writing 0 leaves the bit unchanged. Both windows of a pair read back the same state.
- R4: An access whose first line number is below 32 reads as 0 and changes nothing, even when some of its bits reach line 32 or higher. Lines at or above NUM_LINES read as 0 and are never written. Unmapped addresses read as 0.
- R5: `req_size` code 0, 1 or 2 selects a 1-, 2- or 4-byte access, covering 8, 16 or 32 data bits. Data bits beyond the access size are ignored.
- R6: When security is on, a non-secure access to the group window reads 0 and changes nothing. When security is off, any caller may read and write the group window.
- R7: The access-level window spans 0xD00+0x100 to 0xEFF, with its first line at byte offset times 4. Line first+j occupies data bits 2j+1:2j. This window and the group-modifier window are reachable only by a secure caller while security is on. Otherwise they read 0 and change nothing.
- R8: With security on, a non-secure caller sees and changes enable bits only for lines whose group bit is 1.
- R9: With security on, a non-secure caller may read and set pending bits of a line whose group bit is 1 or whose access level is nonzero.
- R10: With security on, a non-secure caller may read and clear pending bits, and read active bits, of a line whose group bit is 1 or whose access level is 2 or 3. It may write active bits only for lines whose group bit is 1.
- R11: A read request produces `rsp_valid` high with its data one cycle later. A write produces no response.
- R12: `upd_strobe` is high for exactly the one cycle after a write that changed at least one enable or pending bit. It stays low after a write that changed none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_off | input | 1 | 1 turns the security filter off |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Caller is secure |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| grp_vec | output | NUM_LINES | Group bits |
| mod_vec | output | NUM_LINES | Group-modifier bits |
| en_vec | output | NUM_LINES | Enable bits |
| pend_vec | output | NUM_LINES | Pending bits |
| act_vec | output | NUM_LINES | Active bits |
| lvl_vec | output | 2*NUM_LINES | Access levels, two bits per line |
| upd_strobe | output | 1 | Enable or pending state changed |

## Verification
The filter is tried with a fixed set of five lines. Two are non-secure group 1, one has access level 1, one has access level 2, and one has level 0 in group 0. Each window is then written and read from the non-secure side. The resulting masks separate the thresholds of the windows from one another: nonzero for set-pending, at least 2 for clear-pending and active reads, and group only for enable and active writes. Separate patterns check the lane mapping: sparse bits at the window edges, all-ones data with each access size, and an access that starts below line 32 but reaches past it. A final pass repeats accesses with security off, which distinguishes "filter disabled" from "window always closed".

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned ID_W         = 10;
  localparam int unsigned FIRST_SHARED = 32;

  localparam logic [15:0] BASE_GROUP    = 16'h0080;
  localparam logic [15:0] BASE_EN_SET   = 16'h0100;
  localparam logic [15:0] BASE_EN_CLR   = 16'h0180;
  localparam logic [15:0] BASE_PEND_SET = 16'h0200;
  localparam logic [15:0] BASE_PEND_CLR = 16'h0280;
  localparam logic [15:0] BASE_ACT_SET  = 16'h0300;
  localparam logic [15:0] BASE_ACT_CLR  = 16'h0380;
  localparam logic [15:0] BASE_MOD      = 16'h0D00;
  localparam logic [15:0] BASE_LVL      = 16'h0E00;

  typedef enum logic [3:0] {
    W_NONE, W_GROUP, W_EN_SET, W_EN_CLR, W_PEND_SET, W_PEND_CLR,
    W_ACT_SET, W_ACT_CLR, W_MOD, W_LVL
  } win_e;
endpackage

// File: rtl/irq_window_decode.sv
module irq_window_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output win_e              win,
  output logic [ID_W-1:0]   first_id,
  output logic [5:0]        lanes,
  output logic              in_range
);
  localparam int unsigned BLK_W = ADDR_W - 7;

  logic [BLK_W-1:0] blk;
  logic [5:0]       bytes;

  assign blk = addr[ADDR_W-1:7];

  always_comb begin
    win = W_NONE;
    if      (blk == BLK_W'(BASE_GROUP    >> 7)) win = W_GROUP;
    else if (blk == BLK_W'(BASE_EN_SET   >> 7)) win = W_EN_SET;
    else if (blk == BLK_W'(BASE_EN_CLR   >> 7)) win = W_EN_CLR;
    else if (blk == BLK_W'(BASE_PEND_SET >> 7)) win = W_PEND_SET;
    else if (blk == BLK_W'(BASE_PEND_CLR >> 7)) win = W_PEND_CLR;
    else if (blk == BLK_W'(BASE_ACT_SET  >> 7)) win = W_ACT_SET;
    else if (blk == BLK_W'(BASE_ACT_CLR  >> 7)) win = W_ACT_CLR;
    else if (blk == BLK_W'(BASE_MOD      >> 7)) win = W_MOD;
    else if (blk[BLK_W-1:1] == (BLK_W-1)'(BASE_LVL >> 8)) win = W_LVL;
  end

  always_comb begin
    case (size)
      2'd0:    bytes = 6'd1;
      2'd1:    bytes = 6'd2;
      default: bytes = 6'd4;
    endcase
  end

  // two-bit window: 4 lines per byte; one-bit windows: 8 lines per byte
  assign first_id = (win == W_LVL) ? {addr[7:0], 2'b00} : ID_W'({addr[6:0], 3'b000});
  assign lanes    = (win == W_LVL) ? (bytes << 2) : (bytes << 3);
  assign in_range = (win != W_NONE) && (first_id >= ID_W'(FIRST_SHARED));
endmodule

// File: rtl/irq_access_filter.sv
module irq_access_filter
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96
) (
  input  win_e                   win,
  input  logic                   secure,
  input  logic                   sec_off,
  input  logic [NUM_LINES-1:0]   grp_vec,
  input  logic [2*NUM_LINES-1:0] lvl_vec,
  output logic [NUM_LINES-1:0]   rd_ok,
  output logic [NUM_LINES-1:0]   wr_ok
);
  logic ns_lim;
  assign ns_lim = !sec_off && !secure;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic open_grp, lvl_nz, lvl_hi;
    assign open_grp = !ns_lim || grp_vec[g];
    assign lvl_nz   = |lvl_vec[2*g +: 2];
    assign lvl_hi   = lvl_vec[2*g+1];

    always_comb begin
      rd_ok[g] = 1'b0;
      wr_ok[g] = 1'b0;
      case (win)
        W_GROUP:              begin rd_ok[g] = !ns_lim;              wr_ok[g] = !ns_lim; end
        W_MOD, W_LVL:         begin rd_ok[g] = !sec_off && secure;   wr_ok[g] = !sec_off && secure; end
        W_EN_SET, W_EN_CLR:   begin rd_ok[g] = open_grp;             wr_ok[g] = open_grp; end
        W_PEND_SET:           begin rd_ok[g] = open_grp || lvl_nz;   wr_ok[g] = open_grp || lvl_nz; end
        W_PEND_CLR:           begin rd_ok[g] = open_grp || lvl_hi;   wr_ok[g] = open_grp || lvl_hi; end
        W_ACT_SET, W_ACT_CLR: begin rd_ok[g] = open_grp || lvl_hi;   wr_ok[g] = open_grp; end
        default:              begin rd_ok[g] = 1'b0;                 wr_ok[g] = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_off,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [31:0]            req_wdata,
  input  logic                   req_secure,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic [NUM_LINES-1:0]   grp_vec,
  output logic [NUM_LINES-1:0]   mod_vec,
  output logic [NUM_LINES-1:0]   en_vec,
  output logic [NUM_LINES-1:0]   pend_vec,
  output logic [NUM_LINES-1:0]   act_vec,
  output logic [2*NUM_LINES-1:0] lvl_vec,
  output logic                   upd_strobe
);
  win_e                 win;
  logic [ID_W-1:0]      first_id;
  logic [5:0]           lanes;
  logic                 in_range;
  logic [NUM_LINES-1:0] rd_ok, wr_ok, hit, sel_bit, chg;
  logic [4:0]           lane_of [NUM_LINES];
  logic [31:0]          rd_word;
  logic                 wr_req;

  assign wr_req = req_valid && req_write;

  irq_window_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .size(req_size), .win(win),
    .first_id(first_id), .lanes(lanes), .in_range(in_range)
  );

  irq_access_filter #(.NUM_LINES(NUM_LINES)) u_flt (
    .win(win), .secure(req_secure), .sec_off(sec_off),
    .grp_vec(grp_vec), .lvl_vec(lvl_vec), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [ID_W:0] diff;
    logic          wbit, do_wr;
    logic [1:0]    wfld;

    assign diff       = {1'b0, ID_W'(g)} - {1'b0, first_id};
    assign hit[g]     = in_range && !diff[ID_W] && (diff < (ID_W+1)'(lanes));
    assign lane_of[g] = diff[4:0];
    assign wbit       = req_wdata[diff[4:0]];
    assign wfld       = req_wdata[{diff[3:0], 1'b0} +: 2];
    assign do_wr      = wr_req && hit[g] && wr_ok[g];

    always_comb begin
      case (win)
        W_GROUP:              sel_bit[g] = grp_vec[g];
        W_EN_SET, W_EN_CLR:   sel_bit[g] = en_vec[g];
        W_PEND_SET, W_PEND_CLR: sel_bit[g] = pend_vec[g];
        W_ACT_SET, W_ACT_CLR: sel_bit[g] = act_vec[g];
        W_MOD:                sel_bit[g] = mod_vec[g];
        default:              sel_bit[g] = 1'b0;
      endcase
    end

    assign chg[g] = do_wr && wbit &&
                    (((win == W_EN_SET)   && !en_vec[g])   ||
                     ((win == W_EN_CLR)   &&  en_vec[g])   ||
                     ((win == W_PEND_SET) && !pend_vec[g]) ||
                     ((win == W_PEND_CLR) &&  pend_vec[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grp_vec[g]        <= 1'b0;
        mod_vec[g]        <= 1'b0;
        en_vec[g]         <= 1'b0;
        pend_vec[g]       <= 1'b0;
        act_vec[g]        <= 1'b0;
        lvl_vec[2*g +: 2] <= 2'b00;
      end else if (do_wr) begin
        case (win)
          W_GROUP:    grp_vec[g]  <= wbit;
          W_MOD:      mod_vec[g]  <= wbit;
          W_LVL:      lvl_vec[2*g +: 2] <= wfld;
          W_EN_SET:   if (wbit) en_vec[g]   <= 1'b1;
          W_EN_CLR:   if (wbit) en_vec[g]   <= 1'b0;
          W_PEND_SET: if (wbit) pend_vec[g] <= 1'b1;
          W_PEND_CLR: if (wbit) pend_vec[g] <= 1'b0;
          W_ACT_SET:  if (wbit) act_vec[g]  <= 1'b1;
          W_ACT_CLR:  if (wbit) act_vec[g]  <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_LINES; g++) begin
      if (hit[g] && rd_ok[g]) begin
        if (win == W_LVL) rd_word[{lane_of[g][3:0], 1'b0} +: 2] = lvl_vec[2*g +: 2];
        else              rd_word[lane_of[g]] = sel_bit[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      upd_strobe <= 1'b0;
    end else begin
      rsp_valid  <= req_valid && !req_write;
      rsp_rdata  <= (req_valid && !req_write) ? rd_word : '0;
      upd_strobe <= |chg;
    end
  end

  assert_rsp_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_set_never_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && win == W_EN_SET) |=> ((en_vec & $past(en_vec)) == $past(en_vec)));

  assert_clear_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && win == W_PEND_CLR) |=> ((pend_vec & ~$past(pend_vec)) == '0));

  assert_ns_keeps_secure_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_secure) |=> ($stable(mod_vec) && $stable(lvl_vec)));

  assert_strobe_needs_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> $past(wr_req));

  assert_low_lines_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec[FIRST_SHARED-1:0] | pend_vec[FIRST_SHARED-1:0] |
     act_vec[FIRST_SHARED-1:0] | grp_vec[FIRST_SHARED-1:0]) == '0);

  assert_unmapped_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !in_range) |=> (rsp_rdata == '0));
endmodule

// File: tb/sim_irq_state_bank.sv
module sim_irq_state_bank;
  localparam int N = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_off = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, upd_strobe;
  logic [31:0] rsp_rdata;
  logic [N-1:0] grp_vec, mod_vec, en_vec, pend_vec, act_vec;
  logic [2*N-1:0] lvl_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_state_bank #(.NUM_LINES(N), .ADDR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_off(sec_off),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .grp_vec(grp_vec), .mod_vec(mod_vec), .en_vec(en_vec),
    .pend_vec(pend_vec), .act_vec(act_vec), .lvl_vec(lvl_vec),
    .upd_strobe(upd_strobe)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d, input logic sec);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, input logic sec, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    check("R1 enable", 64'(en_vec | pend_vec | act_vec), 64'd0);
    check("R1 group/mod", 64'(grp_vec | mod_vec), 64'd0);
    check("R1 levels", 64'(lvl_vec[127:64] | lvl_vec[63:0] | lvl_vec[191:128]), 64'd0);
    check("R1 outputs", {62'd0, rsp_valid, upd_strobe}, 64'd0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(16'h0104, 2'd2, 32'h0000_0005, 1'b1);
    check("R12 strobe on enable set", 64'(upd_strobe), 64'd1);
    check("R11 no rsp on write", 64'(rsp_valid), 64'd0);
    wr(16'h010B, 2'd0, 32'h0000_0081, 1'b1);
    wr(16'h010D, 2'd0, 32'h0000_0080, 1'b1);
    check("R4 beyond NUM_LINES no strobe", 64'(upd_strobe), 64'd0);
    check("R2 enable lane map", 64'(en_vec[95:32]), 64'h8100_0000_0000_0005);
    rd(16'h0108, 2'd2, 1'b1, d);
    check("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    check("R2 read lines 64..95", 64'(d), 64'h8100_0000);
    rd(16'h0185, 2'd0, 1'b1, d);
    check("R2 clear-enable read 40..47", 64'(d), 64'd0);
    wr(16'h0184, 2'd2, 32'hFFFF_FFFF, 1'b1);
    wr(16'h0188, 2'd2, 32'hFFFF_FFFF, 1'b1);
    check("R3 clear all enables", 64'(en_vec), 64'd0);
  endtask

  task automatic t_size();
    wr(16'h0204, 2'd0, 32'hFFFF_FFFF, 1'b1);
    check("R5 one byte", 64'(pend_vec[63:32]), 64'h0000_00FF);
    wr(16'h0208, 2'd1, 32'hFFFF_FFFF, 1'b1);
    check("R5 two bytes", 64'(pend_vec[95:64]), 64'h0000_FFFF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(16'h0284, 2'd2, 32'h0000_000F, 1'b1);
    check("R3 w1c pending", 64'(pend_vec[63:32]), 64'h0000_00F0);
    check("R12 strobe on clear", 64'(upd_strobe), 64'd1);
    wr(16'h0284, 2'd2, 32'h0000_0000, 1'b1);
    check("R3 zero write no effect", 64'(pend_vec[63:32]), 64'h0000_00F0);
    check("R12 no strobe without change", 64'(upd_strobe), 64'd0);
    rd(16'h0204, 2'd2, 1'b1, d);
    check("R3 set window read", 64'(d), 64'h0000_00F0);
    rd(16'h0284, 2'd2, 1'b1, d);
    check("R3 clear window read", 64'(d), 64'h0000_00F0);
    check("R12 strobe single cycle", 64'(upd_strobe), 64'd0);
    wr(16'h0284, 2'd2, 32'hFFFF_FFFF, 1'b1);
    wr(16'h0288, 2'd2, 32'hFFFF_FFFF, 1'b1);
    check("R3 pending cleared", 64'(pend_vec), 64'd0);
  endtask

  task automatic t_low();
    logic [31:0] d;
    wr(16'h0102, 2'd2, 32'hFFFF_FFFF, 1'b1);
    check("R4 first line below 32 ignored", 64'(en_vec), 64'd0);
    check("R4 no strobe", 64'(upd_strobe), 64'd0);
    wr(16'h0300, 2'd2, 32'hFFFF_FFFF, 1'b1);
    check("R4 low active ignored", 64'(act_vec), 64'd0);
    rd(16'h0100, 2'd2, 1'b1, d);
    check("R4 low read zero", 64'(d), 64'd0);
    rd(16'h0400, 2'd2, 1'b1, d);
    check("R4 unmapped read zero", 64'(d), 64'd0);
  endtask

  task automatic t_ns();
    logic [31:0] d;
    // lines 32,33 group 1; 34 level 1; 35 level 2; 36 level 0, group 0
    wr(16'h0084, 2'd2, 32'h0000_0003, 1'b1);
    wr(16'h0E08, 2'd2, 32'h0000_0090, 1'b1);
    check("R7 level field packing", 64'(lvl_vec[71:64]), 64'h90);
    wr(16'h0104, 2'd2, 32'h0000_001F, 1'b1);
    rd(16'h0104, 2'd2, 1'b0, d);
    check("R8 ns enable read", 64'(d), 64'h3);
    wr(16'h0184, 2'd2, 32'h0000_001F, 1'b0);
    check("R8 ns enable clear", 64'(en_vec[36:32]), 64'h1C);
    wr(16'h0204, 2'd2, 32'h0000_001F, 1'b0);
    check("R9 ns set pending", 64'(pend_vec[36:32]), 64'h0F);
    wr(16'h0204, 2'd2, 32'h0000_0010, 1'b1);
    rd(16'h0204, 2'd2, 1'b0, d);
    check("R9 ns set-pending read", 64'(d), 64'h0F);
    wr(16'h0284, 2'd2, 32'h0000_001F, 1'b0);
    check("R10 ns clear pending", 64'(pend_vec[36:32]), 64'h14);
    wr(16'h0204, 2'd2, 32'h0000_001F, 1'b1);
    rd(16'h0284, 2'd2, 1'b0, d);
    check("R10 ns clear-pending read", 64'(d), 64'h0B);
    wr(16'h0304, 2'd2, 32'h0000_001F, 1'b1);
    rd(16'h0384, 2'd2, 1'b0, d);
    check("R10 ns active read", 64'(d), 64'h0B);
    wr(16'h0384, 2'd2, 32'h0000_001F, 1'b0);
    check("R10 ns active write", 64'(act_vec[36:32]), 64'h1C);
    wr(16'h0084, 2'd2, 32'h0000_00FF, 1'b0);
    check("R6 ns group write ignored", 64'(grp_vec[39:32]), 64'h03);
    rd(16'h0084, 2'd2, 1'b0, d);
    check("R6 ns group read zero", 64'(d), 64'd0);
    wr(16'h0E08, 2'd2, 32'h0000_FFFF, 1'b0);
    check("R7 ns level write ignored", 64'(lvl_vec[71:64]), 64'h90);
    rd(16'h0E08, 2'd2, 1'b0, d);
    check("R7 ns level read zero", 64'(d), 64'd0);
    rd(16'h0E08, 2'd0, 1'b1, d);
    check("R7 secure level read", 64'(d), 64'h90);
    wr(16'h0D04, 2'd0, 32'h0000_0001, 1'b1);
    check("R7 secure modifier write", 64'(mod_vec[39:32]), 64'h01);
    rd(16'h0D04, 2'd0, 1'b1, d);
    check("R7 secure modifier read", 64'(d), 64'h01);
  endtask

  task automatic t_sec_off();
    logic [31:0] d;
    @(negedge clk);
    sec_off = 1'b1;
    rd(16'h0D04, 2'd0, 1'b1, d);
    check("R7 modifier hidden when security off", 64'(d), 64'd0);
    wr(16'h0D04, 2'd0, 32'h0, 1'b1);
    check("R7 modifier write ignored when security off", 64'(mod_vec[39:32]), 64'h01);
    rd(16'h0E08, 2'd0, 1'b1, d);
    check("R7 level hidden when security off", 64'(d), 64'd0);
    wr(16'h0084, 2'd2, 32'h0000_0100, 1'b0);
    check("R6 group writable when security off", 64'(grp_vec[63:32]), 64'h100);
    wr(16'h0184, 2'd2, 32'hFFFF_FFFF, 1'b0);
    check("R8 filter off for enables", 64'(en_vec[63:32]), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_map();
    t_size();
    t_w1c();
    t_low();
    t_ns();
    t_sec_off();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule